// File: doc/BRIEF.md
# Debounced Digital I/O with Edge Interrupts

This block serves a bank of general-purpose digital lines. Each line has a direction bit that drives the pad's output enable, and an output data bit. Every pad value is brought into the clock domain through a two-stage synchronizer. After that it passes through a filter that can be switched on per line. A line that is filtered only takes a new level once the synchronized value has differed from the accepted level for longer than a programmed time. All filtered lines share this one time setting. Lines with the filter off take the synchronized value directly.

The filtered levels feed an edge detector. It compares each line's filtered value with the filtered value from the previous cycle. Separate rising and falling enables per line decide which transitions set a pending bit. Software clears pending bits by writing 1 to them. A single interrupt output is raised while any bit is pending and the master enable is set. Software reaches everything through a word-wide register port with a combinational read path and a single-cycle write strobe.

Top module: `dio_debounce_irq`

## Requirements
- R1: The direction register (address 0) drives `pin_oe` and the output register (address 1) drives `pin_out`, one bit per line. A direction bit of 1 makes the line an output and 0 makes it an input. A write takes effect on the clock edge that samples it.
- R2: Each pad value passes through two synchronizing flops. On a line whose filter is off, the filtered value follows the pad value three rising edges after the pad changes (edges k, k+1, k+2, where k is the first edge that samples the change).
- R3: On a line whose filter is on, a new level is accepted only after the synchronized value has differed from the accepted level for more than T consecutive cycles. T is the debounce time. A pulse that lasts T cycles or fewer is dropped.
- R4: The debounce enables (address 3, one bit per line) and the shared debounce time T (address 4) are read/write. On a filtered line, a stable pad change becomes visible after edge k+2+T. T = 0 therefore behaves like an unfiltered line.
- R5: The input register (address 2, read-only) returns the filtered value of every line. This includes lines whose direction is output.
- R6: When a line's rising enable (address 5) is set, that line's pending bit is set one edge after its filtered value goes from 0 to 1.
- R7: When a line's falling enable (address 6) is set, that line's pending bit is set one edge after its filtered value goes from 1 to 0.
- R8: With both enables set, a line pends on either transition. With neither set, it never pends.
- R9: The pending register (address 7) is cleared by writing 1 to a bit. Writing 0 leaves a bit unchanged. If a new edge arrives in the same cycle as a clear, the bit stays set.
- R10: `irq` is high exactly while the master enable (address 8, bit 0) is 1 and at least one pending bit is set. Pending bits are recorded even while the master enable is 0.
- R11: After reset, all registers, the filtered values and `irq` are 0.
- R12: Addresses 9 to 15 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | LINES | Raw pad levels |
| pin_out | output | LINES | Output data to pads |
| pin_oe | output | LINES | Pad output enables (direction) |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (combinational from reg_addr) |
| irq | output | 1 | Interrupt request |

## Verification
Counting from the first edge that samples a pad change, the filtered value reaches the input register after edge k+2 on an unfiltered line and after edge k+2+T on a filtered one. The pending bit and `irq` follow one edge later. Register writes are visible right after the edge that samples them, and reads are combinational. The bench drives its inputs one nanosecond after a rising edge. Its reference model advances at each rising edge, and all outputs are compared at the following falling edge, so every result is checked in the cycle it is due. Directed checks probe the boundary cycles one edge before and at the edge where a level should appear.

// File: rtl/dbio_pkg.sv
package dbio_pkg;
   localparam int REG_AW = 4;

   typedef enum logic [REG_AW-1:0] {
      RG_DIR    = 4'd0,
      RG_DOUT   = 4'd1,
      RG_DIN    = 4'd2,
      RG_DBEN   = 4'd3,
      RG_DBTIME = 4'd4,
      RG_RISE   = 4'd5,
      RG_FALL   = 4'd6,
      RG_PEND   = 4'd7,
      RG_CTRL   = 4'd8
   } reg_sel_e;
endpackage

// File: rtl/dbio_sync.sv
module dbio_sync #(
   parameter int LINES  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw_i,
   output logic [LINES-1:0] sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dbio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [LINES-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= raw_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbio_filter.sv
module dbio_filter #(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [TIME_W-1:0] limit_i,
   input  logic              sync_i,
   output logic              filt_o
);
   logic [TIME_W-1:0] cnt_q;
   logic              filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         filt_q <= 1'b0;
      end else if (!en_i) begin
         filt_q <= sync_i;
         cnt_q  <= '0;
      end else if (sync_i == filt_q) begin
         cnt_q <= '0;
      end else if (cnt_q >= limit_i) begin
         filt_q <= sync_i;
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign filt_o = filt_q;

   // R3
   accept_after_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_i) && !$stable(filt_q)) |-> ($past(cnt_q) >= $past(limit_i)));

   // R2
   bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_i) |-> (filt_q == $past(sync_i)));
endmodule

// File: rtl/dbio_edge.sv
module dbio_edge #(
   parameter int LINES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] filt_i,
   input  logic [LINES-1:0] rise_en_i,
   input  logic [LINES-1:0] fall_en_i,
   input  logic [LINES-1:0] clr_i,
   input  logic             mie_i,
   output logic [LINES-1:0] pend_o,
   output logic             irq_o
);
   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] pend_q;
   logic [LINES-1:0] hit;

   assign hit = (rise_en_i & filt_i & ~prev_q) | (fall_en_i & ~filt_i & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= filt_i;
         pend_q <= (pend_q & ~clr_i) | hit;
      end
   end

   assign pend_o = pend_q;
   assign irq_o  = mie_i & (|pend_q);

   // R9
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~hit)) |=> ((pend_q & $past(clr_i & ~hit)) == '0));

   // R6
   pend_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~$past(pend_q) & ~$past(hit)) == '0));
endmodule

// File: rtl/dio_debounce_irq.sv
module dio_debounce_irq
   import dbio_pkg::*;
#(
   parameter int LINES  = 16,
   parameter int DATA_W = 16,
   parameter int TIME_W = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  pin_in,
   output logic [LINES-1:0]  pin_out,
   output logic [LINES-1:0]  pin_oe,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   generate
      if (LINES < 1 || LINES > DATA_W) begin : g_bad_lines
         $error("dio_debounce_irq: LINES must be within 1..DATA_W");
      end
      if (TIME_W < 1 || TIME_W > DATA_W) begin : g_bad_time
         $error("dio_debounce_irq: TIME_W must be within 1..DATA_W");
      end
   endgenerate

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_addr);

   logic [LINES-1:0]  dir_q, dout_q, dben_q, rise_q, fall_q;
   logic [TIME_W-1:0] dbtime_q;
   logic              mie_q;
   logic [LINES-1:0]  sync_v, filt_v, pend_v, clr_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q    <= '0;
         dout_q   <= '0;
         dben_q   <= '0;
         rise_q   <= '0;
         fall_q   <= '0;
         dbtime_q <= '0;
         mie_q    <= 1'b0;
      end else if (reg_wr) begin
         case (sel)
            RG_DIR:    dir_q    <= reg_wdata[LINES-1:0];
            RG_DOUT:   dout_q   <= reg_wdata[LINES-1:0];
            RG_DBEN:   dben_q   <= reg_wdata[LINES-1:0];
            RG_DBTIME: dbtime_q <= reg_wdata[TIME_W-1:0];
            RG_RISE:   rise_q   <= reg_wdata[LINES-1:0];
            RG_FALL:   fall_q   <= reg_wdata[LINES-1:0];
            RG_CTRL:   mie_q    <= reg_wdata[0];
            default:   ;
         endcase
      end
   end

   assign clr_v   = (reg_wr && sel == RG_PEND) ? reg_wdata[LINES-1:0] : '0;
   assign pin_oe  = dir_q;
   assign pin_out = dout_q;

   dbio_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (pin_in),
      .sync_o (sync_v)
   );

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         dbio_filter #(.TIME_W(TIME_W)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (dben_q[i]),
            .limit_i (dbtime_q),
            .sync_i  (sync_v[i]),
            .filt_o  (filt_v[i])
         );
      end
   endgenerate

   dbio_edge #(.LINES(LINES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .filt_i    (filt_v),
      .rise_en_i (rise_q),
      .fall_en_i (fall_q),
      .clr_i     (clr_v),
      .mie_i     (mie_q),
      .pend_o    (pend_v),
      .irq_o     (irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (sel)
         RG_DIR:    reg_rdata[LINES-1:0]  = dir_q;
         RG_DOUT:   reg_rdata[LINES-1:0]  = dout_q;
         RG_DIN:    reg_rdata[LINES-1:0]  = filt_v;
         RG_DBEN:   reg_rdata[LINES-1:0]  = dben_q;
         RG_DBTIME: reg_rdata[TIME_W-1:0] = dbtime_q;
         RG_RISE:   reg_rdata[LINES-1:0]  = rise_q;
         RG_FALL:   reg_rdata[LINES-1:0]  = fall_q;
         RG_PEND:   reg_rdata[LINES-1:0]  = pend_v;
         RG_CTRL:   reg_rdata[0]          = mie_q;
         default:   reg_rdata = '0;
      endcase
   end

   // R1
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_wr && reg_addr == RG_DIR) |-> (pin_oe == $past(reg_wdata[LINES-1:0])));

   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> mie_q);
endmodule

// File: tb/test_dio_debounce_irq.sv
`timescale 1ns/1ps
module test_dio_debounce_irq;
   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_out, pin_oe;
   logic          reg_wr = 1'b0;
   logic [3:0]    reg_addr = 4'd2;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2 clk = ~clk;

   dio_debounce_irq i_dio_debounce_irq (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   // reference model state
   bit [N-1:0] m_s1, m_s2, m_filt, m_prev, m_pend;
   bit [N-1:0] m_dir, m_out, m_den, m_rise, m_fall;
   int         m_T;
   bit         m_mie;
   int         run [N];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_filt = '0; m_prev = '0; m_pend = '0;
         m_dir = '0; m_out = '0; m_den = '0; m_rise = '0; m_fall = '0;
         m_T = 0; m_mie = 0;
         for (int i = 0; i < N; i++) run[i] = 0;
      end else begin
         bit [N-1:0] hit, nf, clr;
         hit = (m_rise & m_filt & ~m_prev) | (m_fall & ~m_filt & m_prev);
         clr = (reg_wr && reg_addr == 4'd7) ? reg_wdata : '0;
         m_pend = (m_pend & ~clr) | hit;
         m_prev = m_filt;
         nf = m_filt;
         for (int i = 0; i < N; i++) begin
            if (!m_den[i]) begin
               nf[i] = m_s2[i]; run[i] = 0;
            end else if (m_s2[i] == m_filt[i]) begin
               run[i] = 0;
            end else begin
               run[i]++;
               if (run[i] > m_T) begin nf[i] = m_s2[i]; run[i] = 0; end
            end
         end
         m_filt = nf;
         m_s2 = m_s1;
         m_s1 = pin_in;
         if (reg_wr) begin
            case (reg_addr)
               4'd0: m_dir  = reg_wdata;
               4'd1: m_out  = reg_wdata;
               4'd3: m_den  = reg_wdata;
               4'd4: m_T    = int'(reg_wdata);
               4'd5: m_rise = reg_wdata;
               4'd6: m_fall = reg_wdata;
               4'd8: m_mie  = reg_wdata[0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [15:0] exp_rd(input logic [3:0] a);
      case (a)
         4'd0: return m_dir;
         4'd1: return m_out;
         4'd2: return m_filt;
         4'd3: return m_den;
         4'd4: return m_T[15:0];
         4'd5: return m_rise;
         4'd6: return m_fall;
         4'd7: return m_pend;
         4'd8: return {15'd0, m_mie};
         default: return 16'h0;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] a);
      case (a)
         4'd0, 4'd1: return "R1";
         4'd2:       return "R5";
         4'd3, 4'd4: return "R4";
         4'd5, 4'd6: return "R8";
         4'd7:       return "R9";
         4'd8:       return "R10";
         default:    return "R12";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R10 irq", {31'd0, irq}, {31'd0, m_mie & (|m_pend)});
         chk("R1 pin_oe", {16'd0, pin_oe}, {16'd0, m_dir});
         chk("R1 pin_out", {16'd0, pin_out}, {16'd0, m_out});
         chk(req_of(reg_addr), {16'd0, reg_rdata}, {16'd0, exp_rd(reg_addr)});
      end
   end

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_addr = 4'd2;
   endtask

   task automatic set_pins(input logic [N-1:0] v);
      @(posedge clk); #1;
      pin_in = v;
   endtask

   task automatic look(input logic [3:0] a, input string req, input logic [15:0] mask,
                       input logic [15:0] exp);
      @(posedge clk); #1;
      reg_addr = a;
      @(negedge clk);
      chk(req, {16'd0, reg_rdata & mask}, {16'd0, exp});
      @(posedge clk); #1;
      reg_addr = 4'd2;
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R11: reset state
      @(negedge clk);
      chk("R11 input reg", {16'd0, reg_rdata}, 32'd0);
      chk("R11 irq", {31'd0, irq}, 32'd0);
      chk("R11 pin_oe", {16'd0, pin_oe}, 32'd0);
      look(4'd7, "R11 pending", 16'hFFFF, 16'h0000);
      look(4'd4, "R11 debounce time", 16'hFFFF, 16'h0000);

      // R2: unfiltered line 0, value due after edge k+2
      set_pins(16'h0001);
      wait_edges(2);
      @(negedge clk) chk("R2 before k+2", {31'd0, reg_rdata[0]}, 32'd0);
      @(posedge clk); @(negedge clk) chk("R2 at k+2", {31'd0, reg_rdata[0]}, 32'd1);

      // R1: direction and output registers
      wr(4'd0, 16'h00F1);
      wr(4'd1, 16'h5A5A);
      @(negedge clk);
      chk("R1 oe", {16'd0, pin_oe}, 32'h00F1);
      chk("R1 out", {16'd0, pin_out}, 32'h5A5A);

      // R5: line 0 is an output, input register still tracks the pad
      set_pins(16'h0000);
      wait_edges(3);
      @(negedge clk) chk("R5 output line reads pad", {31'd0, reg_rdata[0]}, 32'd0);

      // R3/R4: filter on line 3 with T = 5
      wr(4'd4, 16'd5);
      wr(4'd3, 16'h0008);
      set_pins(16'h0008);
      wait_edges(3);
      set_pins(16'h0000);
      wait_edges(20);
      @(negedge clk) chk("R3 short pulse dropped", {31'd0, reg_rdata[3]}, 32'd0);
      set_pins(16'h0008);
      wait_edges(6);
      @(negedge clk) chk("R4 before k+2+T", {31'd0, reg_rdata[3]}, 32'd0);
      wait_edges(2);
      @(negedge clk) chk("R3 accepted at k+2+T", {31'd0, reg_rdata[3]}, 32'd1);

      // R4: T = 0 on a filtered line behaves like bypass
      wr(4'd4, 16'd0);
      set_pins(16'h0000);
      wait_edges(2);
      @(negedge clk) chk("R4 T0 before k+2", {31'd0, reg_rdata[3]}, 32'd1);
      @(posedge clk); @(negedge clk) chk("R4 T0 at k+2", {31'd0, reg_rdata[3]}, 32'd0);

      // R6/R7/R8 with master enable off (R10)
      wr(4'd5, 16'h0012);   // rise on lines 1 and 4
      wr(4'd6, 16'h0024);   // fall on lines 2 and 5
      set_pins(16'h0036);   // lines 1,2,4,5 go high
      wait_edges(6);
      look(4'd7, "R6 rise pends, fall does not", 16'hFFFF, 16'h0012);
      @(negedge clk) chk("R10 masked irq", {31'd0, irq}, 32'd0);
      wr(4'd8, 16'h0001);
      @(negedge clk) chk("R10 irq with enable", {31'd0, irq}, 32'd1);
      // R9: writing 0 changes nothing, writing 1 clears
      wr(4'd7, 16'h0000);
      look(4'd7, "R9 write zero", 16'hFFFF, 16'h0012);
      wr(4'd7, 16'h0012);
      look(4'd7, "R9 write one clears", 16'hFFFF, 16'h0000);
      @(negedge clk) chk("R10 irq drops", {31'd0, irq}, 32'd0);
      set_pins(16'h0000);
      wait_edges(6);
      look(4'd7, "R7 fall pends", 16'hFFFF, 16'h0024);
      wr(4'd7, 16'hFFFF);
      // R8: both enables on line 6
      wr(4'd5, 16'h0040);
      wr(4'd6, 16'h0040);
      set_pins(16'h0040);
      wait_edges(6);
      look(4'd7, "R8 both rise", 16'hFFFF, 16'h0040);
      wr(4'd7, 16'h0040);
      set_pins(16'h0000);
      wait_edges(6);
      look(4'd7, "R8 both fall", 16'hFFFF, 16'h0040);
      wr(4'd7, 16'h0040);

      // R12: unmapped address
      wr(4'd12, 16'hFFFF);
      look(4'd12, "R12 unmapped reads zero", 16'hFFFF, 16'h0000);

      // mixed random traffic, checked by the model every cycle
      begin
         logic [31:0] s;
         s = 32'h1ACE_B00C;
         for (int c = 0; c < 4000; c++) begin
            logic [31:0] a, b;
            s ^= s << 13; s ^= s >> 17; s ^= s << 5; a = s;
            s ^= s << 13; s ^= s >> 17; s ^= s << 5; b = s;
            @(posedge clk); #1;
            reg_wr = 1'b0;
            if ((c % 3) == 0) pin_in = pin_in ^ (a[15:0] & b[15:0] & a[31:16]);
            reg_addr = b[19:16];
            if (b[27:24] == 4'd0) begin
               reg_wr = 1'b1;
               reg_wdata = (b[19:16] == 4'd4) ? {13'd0, a[2:0]} : a[31:16];
            end
         end
         @(posedge clk); #1 reg_wr = 1'b0; reg_addr = 4'd2;
      end
      wait_edges(4);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R2 watchdog: got running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule